// File: doc/BRIEF.md
# Streaming UDP Datagram Sender with Checksum Trailer

This block builds UDP datagrams on the fly from a stream of sample bytes. The whole packet is never held in memory. The checksum field of each UDP header is filled with a preset constant, so the header can be sent before any payload byte is known.

While the header and payload bytes leave the block, it keeps a running ones'-complement sum over three things: the IPv4 pseudo-header, the UDP header and the payload. After the last data byte it appends a two-byte trailer word. The trailer makes the whole datagram add up correctly against the constant already sent.

A packet starts when a payload byte is offered while the block is idle. The block then sends the 8-byte header and passes `DATA_BYTES` payload bytes through one at a time. Bytes that arrive while the packet is in progress go straight into it. The two trailer bytes come last. Both sides use a byte-wide valid/ready handshake. Ethernet framing, the frame CRC and the IP header checksum are handled downstream.

Top module: `udp_csum_trailer_tx`

## Requirements
- R1: Each datagram begins with 8 header bytes in big-endian order:
  - bytes 0–1: source port;
  - bytes 2–3: destination port;
  - bytes 4–5: UDP length, equal to `DATA_BYTES` + 10;
  - bytes 6–7: the checksum field.

  The port and address inputs are sampled in the idle cycle in which the packet starts.
- R2: The checksum field (header bytes 6–7) carries the configured constant, whatever the payload.
- R3: A configured constant of 0x0000 is sent as 0xFFFF, because a zero field means "no checksum"; the trailer is computed against the value actually sent.
- R4: Payload bytes pass through unchanged, in order, each exactly once, directly after the header. `in_ready` is high only while payload bytes are being accepted and never during the header or the trailer.
- R5: Exactly two trailer bytes follow the `DATA_BYTES` payload bytes, high byte first, and `out_last` is high on the second trailer byte only.
- R6: The trailer word is the bitwise inverse of the folded 16-bit ones'-complement sum (end-around carry, big-endian words) over three groups of words:
  - the pseudo-header: source IP, destination IP, 0x0011 and the UDP length;
  - the UDP header;
  - the payload.

  The sum over all these words plus the trailer is therefore 0xFFFF.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Stalls and input gaps neither drop nor double-count a byte in the running sum.
- R8: A datagram is exactly `DATA_BYTES` + 10 bytes long. `DATA_BYTES` must be even, so that the trailer lands on a word boundary. The default of 2362 gives a 2392-byte IPv4 packet, which needs jumbo-frame support.
- R9: After the last trailer byte is accepted, `out_valid` is low for at least one cycle. The next packet uses freshly sampled configuration.
- R10: Out of reset, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_ip | input | 32 | IPv4 source address for the pseudo-header |
| cfg_dst_ip | input | 32 | IPv4 destination address for the pseudo-header |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_csum_const | input | 16 | Fixed value placed in the checksum field |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte accepted this cycle if valid |
| out_data | output | 8 | Datagram byte |
| out_valid | output | 1 | Datagram byte offered |
| out_ready | input | 1 | Downstream accepts the byte |
| out_last | output | 1 | Final byte of the datagram |

## Verification
Some properties are checked by assertions on every cycle:
- the output holds under back-pressure;
- the running sum stays unchanged whenever no byte moves;
- the sent constant is never zero during a packet;
- the datagram length is counted out to exactly the UDP length;
- the output goes idle after the last byte.

Only the bench scenarios show that the emitted byte values are correct. The bench compares every byte against a scoreboard built from its own checksum arithmetic. It also re-sums each received datagram, trailer included, to 0xFFFF across several payload patterns. These include all-ones and all-zero payloads, the zero-constant substitution, random stalls, input gaps and configuration changes between packets.

// File: rtl/udp_trailer_pkg.sv
package udp_trailer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_TRL
    } tx_state_e;

    typedef struct packed {
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [15:0] csum;
    } hdr_cfg_t;

    // 16-bit ones'-complement addition with end-around carry
    function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/udp_pseudo_sum.sv
module udp_pseudo_sum
    import udp_trailer_pkg::*;
(
    input  logic [31:0] src_ip,
    input  logic [31:0] dst_ip,
    input  logic [15:0] udp_len,
    output logic [15:0] sum
);
    logic [15:0] s0, s1, s2, s3, s4;

    always_comb begin
        s0  = oc_add16(src_ip[31:16], src_ip[15:0]);
        s1  = oc_add16(s0, dst_ip[31:16]);
        s2  = oc_add16(s1, dst_ip[15:0]);
        s3  = oc_add16(s2, 16'h0011);
        s4  = oc_add16(s3, udp_len);
        sum = s4;
    end
endmodule

// File: rtl/udp_hdr_byte.sv
module udp_hdr_byte
    import udp_trailer_pkg::*;
(
    input  hdr_cfg_t    hdr,
    input  logic [15:0] udp_len,
    input  logic [2:0]  idx,
    output logic [7:0]  data
);
    always_comb begin
        case (idx)
            3'd0:    data = hdr.src_port[15:8];
            3'd1:    data = hdr.src_port[7:0];
            3'd2:    data = hdr.dst_port[15:8];
            3'd3:    data = hdr.dst_port[7:0];
            3'd4:    data = udp_len[15:8];
            3'd5:    data = udp_len[7:0];
            3'd6:    data = hdr.csum[15:8];
            default: data = hdr.csum[7:0];
        endcase
    end
endmodule

// File: rtl/udp_csum_acc.sv
module udp_csum_acc
    import udp_trailer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] load_val,
    input  logic        add,
    input  logic [7:0]  add_byte,
    input  logic        add_hi,
    output logic [15:0] sum
);
    logic [15:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (load)
            sum_d = load_val;
        else if (add)
            sum_d = oc_add16(sum_q, add_hi ? {add_byte, 8'h00} : {8'h00, add_byte});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    // R7
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !add) |=> $stable(sum_q));
endmodule

// File: rtl/udp_csum_trailer_tx.sv
module udp_csum_trailer_tx
    import udp_trailer_pkg::*;
#(
    parameter int DATA_BYTES = 2362
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_src_ip,
    input  logic [31:0] cfg_dst_ip,
    input  logic [15:0] cfg_src_port,
    input  logic [15:0] cfg_dst_port,
    input  logic [15:0] cfg_csum_const,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_last
);
    localparam int          UDP_LEN_I = DATA_BYTES + 10;
    localparam logic [15:0] UDP_LEN   = 16'(UDP_LEN_I);
    localparam int          CNT_W     = $clog2(DATA_BYTES + 8);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(7);

    typedef struct packed {
        tx_state_e       st;
        logic [CNT_W-1:0] idx;
        hdr_cfg_t        hdr;
    } tx_reg_t;

    tx_reg_t r_d, r_q;

    logic [15:0] pseudo_sum;
    logic [15:0] run_sum;
    logic [15:0] trailer;
    logic [7:0]  hdr_data;
    logic        acc_load, acc_add, acc_hi;
    logic [7:0]  acc_byte;
    logic [15:0] csum_eff;

    udp_pseudo_sum u_pseudo (
        .src_ip  (cfg_src_ip),
        .dst_ip  (cfg_dst_ip),
        .udp_len (UDP_LEN),
        .sum     (pseudo_sum)
    );

    udp_hdr_byte u_hdr (
        .hdr     (r_q.hdr),
        .udp_len (UDP_LEN),
        .idx     (r_q.idx[2:0]),
        .data    (hdr_data)
    );

    udp_csum_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (pseudo_sum),
        .add      (acc_add),
        .add_byte (acc_byte),
        .add_hi   (acc_hi),
        .sum      (run_sum)
    );

    assign trailer  = ~run_sum;
    assign csum_eff = (cfg_csum_const == 16'h0000) ? 16'hFFFF : cfg_csum_const;

    always_comb begin
        r_d       = r_q;
        acc_load  = 1'b0;
        acc_add   = 1'b0;
        acc_byte  = 8'h00;
        acc_hi    = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.st           = ST_HDR;
                    r_d.idx          = '0;
                    r_d.hdr.src_port = cfg_src_port;
                    r_d.hdr.dst_port = cfg_dst_port;
                    r_d.hdr.csum     = csum_eff;
                    acc_load         = 1'b1;
                end
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_data;
                if (out_ready) begin
                    acc_add  = 1'b1;
                    acc_byte = hdr_data;
                    acc_hi   = ~r_q.idx[0];
                    if (r_q.idx == LAST_HDR) begin
                        r_d.st  = ST_PAY;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + CNT_W'(1);
                    end
                end
            end
            ST_PAY: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    acc_add  = 1'b1;
                    acc_byte = in_data;
                    acc_hi   = ~r_q.idx[0];
                    if (r_q.idx == LAST_DATA) begin
                        r_d.st  = ST_TRL;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + CNT_W'(1);
                    end
                end
            end
            default: begin
                out_valid = 1'b1;
                out_data  = r_q.idx[0] ? trailer[7:0] : trailer[15:8];
                out_last  = r_q.idx[0];
                if (out_ready) begin
                    if (r_q.idx[0]) begin
                        r_d.st  = ST_IDLE;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.idx <= '0;
            r_q.hdr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // byte position counter used only by the length check below
    logic [15:0] pos_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (out_valid && out_ready)
            pos_q <= out_last ? 16'd0 : pos_q + 16'd1;
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    const_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.hdr.csum != 16'h0000));

    // R8
    pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> (pos_q == UDP_LEN - 16'd1));

    // R9
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: tb/udp_csum_trailer_tx_test.sv
module udp_csum_trailer_tx_test;
    localparam int DB   = 12;
    localparam int ULEN = DB + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_src_ip = '0, cfg_dst_ip = '0;
    logic [15:0] cfg_src_port = '0, cfg_dst_port = '0, cfg_csum_const = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_last;

    always #5 clk = ~clk;

    udp_csum_trailer_tx #(.DATA_BYTES(DB)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
        .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
        .cfg_csum_const(cfg_csum_const),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    bit         last_q[$];
    string      tag_q[$];
    logic [31:0] pkt_pseudo;
    bit stall_mode = 1'b0;
    bit mon_en = 1'b0;
    logic [7:0] pl [DB];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [31:0] t;
        t = s;
        while (t[31:16] != 0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
        return t[15:0];
    endfunction

    task automatic push(input logic [7:0] b, input bit lst, input string tag);
        exp_q.push_back(b);
        last_q.push_back(lst);
        tag_q.push_back(tag);
    endtask

    // out_ready driver
    always begin
        @(posedge clk); #1;
        out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // monitor / scoreboard
    int          pos = 0;
    logic [7:0]  hi_b = '0;
    logic [31:0] wsum = '0;
    int          win_err = 0;
    bit          hold_pend = 1'b0;
    logic [7:0]  hold_data = '0;
    bit          after_last = 1'b0;

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (after_last) begin
                chk(!out_valid, "R9", "out_valid after last byte", int'(out_valid), 0);
                after_last = 1'b0;
            end
            if (hold_pend)
                chk(out_valid && out_data == hold_data, "R7", "held byte under stall",
                    int'(out_data), int'(hold_data));
            hold_pend = out_valid && !out_ready;
            hold_data = out_data;
            if (in_ready && !(pos >= 8 && pos < 8 + DB)) win_err++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected output byte", int'(out_data), -1);
                end else begin
                    logic [7:0] eb;
                    bit el;
                    string tg;
                    eb = exp_q.pop_front();
                    el = last_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(out_data == eb, tg, $sformatf("byte %0d", pos), int'(out_data), int'(eb));
                    chk(out_last == el, "R5", $sformatf("out_last at byte %0d", pos),
                        int'(out_last), int'(el));
                    if (pos % 2 == 0) hi_b = out_data;
                    else wsum = wsum + {16'd0, hi_b, out_data};
                    pos++;
                    if (el) begin
                        chk(fold(wsum + pkt_pseudo) == 16'hFFFF, "R6", "datagram sum incl trailer",
                            int'(fold(wsum + pkt_pseudo)), 16'hFFFF);
                        chk(win_err == 0, "R4", "in_ready outside payload window", win_err, 0);
                        chk(pos == ULEN, "R8", "datagram length", pos, ULEN);
                        pos = 0; wsum = '0; win_err = 0;
                        after_last = 1'b1;
                    end
                end
            end
        end
    end

    task automatic run_packet(input logic [31:0] sip, input logic [31:0] dip,
                              input logic [15:0] sp, input logic [15:0] dp,
                              input logic [15:0] cs, input bit gaps);
        logic [15:0] cs_eff, trl;
        logic [31:0] s;
        string ctag;
        cs_eff = (cs == 16'h0000) ? 16'hFFFF : cs;
        ctag = (cs == 16'h0000) ? "R3" : "R2";
        cfg_src_ip = sip; cfg_dst_ip = dip;
        cfg_src_port = sp; cfg_dst_port = dp; cfg_csum_const = cs;
        pkt_pseudo = {16'd0, sip[31:16]} + {16'd0, sip[15:0]} + {16'd0, dip[31:16]} +
                     {16'd0, dip[15:0]} + 32'h11 + ULEN;
        push(sp[15:8], 0, "R1"); push(sp[7:0], 0, "R1");
        push(dp[15:8], 0, "R1"); push(dp[7:0], 0, "R1");
        push(8'(ULEN >> 8), 0, "R1"); push(8'(ULEN), 0, "R1");
        push(cs_eff[15:8], 0, ctag); push(cs_eff[7:0], 0, ctag);
        s = pkt_pseudo + sp + dp + ULEN + cs_eff;
        for (int i = 0; i < DB; i += 2) s = s + {16'd0, pl[i], pl[i+1]};
        trl = ~fold(s);
        for (int i = 0; i < DB; i++) push(pl[i], 0, "R4");
        push(trl[15:8], 0, "R6");
        push(trl[7:0], 1, "R5");
        @(posedge clk); #1;
        for (int i = 0; i < DB; i++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                in_valid = 1'b0;
                repeat ($urandom_range(1, 3)) begin @(posedge clk); #1; end
            end
            in_valid = 1'b1;
            in_data  = pl[i];
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !in_ready, "R10", "idle in reset", int'({out_valid, in_ready}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready, "R10", "idle after reset", int'({out_valid, in_ready}), 0);
        mon_en = 1'b1;

        // incrementing payload, no stalls
        for (int i = 0; i < DB; i++) pl[i] = 8'(i * 17 + 3);
        stall_mode = 1'b0;
        run_packet(32'hC0A80102, 32'hC0A80164, 16'd4000, 16'd5000, 16'h1234, 1'b0);

        // all-ones payload, stalls and gaps, new config (R9)
        for (int i = 0; i < DB; i++) pl[i] = 8'hFF;
        stall_mode = 1'b1;
        run_packet(32'h0A000001, 32'h0A0000FE, 16'hFFFF, 16'h0001, 16'hBEEF, 1'b1);

        // all-zero payload with zero constant (R3)
        for (int i = 0; i < DB; i++) pl[i] = 8'h00;
        run_packet(32'h00000000, 32'hFFFFFFFF, 16'h0000, 16'h8000, 16'h0000, 1'b0);

        // random payload, stalls and gaps
        for (int i = 0; i < DB; i++) pl[i] = 8'($urandom_range(0, 255));
        run_packet(32'hAC100A05, 32'hAC100A06, 16'd1234, 16'd4321, 16'h0001, 1'b1);

        // random payload, no stalls, constant 0xFFFF
        stall_mode = 1'b0;
        for (int i = 0; i < DB; i++) pl[i] = 8'($urandom_range(0, 255));
        run_packet(32'h7F000001, 32'h7F000001, 16'd9, 16'd9, 16'hFFFF, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule